// File: doc/BRIEF.md
# I2C Byte and Condition Sequencer

This block is the middle layer of an I2C master. The layer above hands it one byte-level operation at a time: a START condition, a STOP condition, a byte write that returns the slave's acknowledge, or a byte read that sends an acknowledge level chosen by the caller. The sequencer breaks each operation into a fixed series of line micro-steps. Each micro-step names the level of SDA, the level of SCL, and whether SDA is to be sampled. It hands these one at a time to the line driver below through a request/done handshake.

Every micro-step waits for the driver, and the driver waits for the bus tick, so the block needs no timing of its own. Bytes move most significant bit first. Each bit takes three micro-steps: set SDA with SCL low, release SCL, then pull SCL low again. When a byte completes, a one-cycle `done` pulse returns the received byte and the acknowledge status to the caller.

Top module: `i2c_byte_seq`

## Requirements
- R1: After reset `busy`, `done` and `stepReq` are 0, `rxByte` is 0 and `ackStat` is 1.
- R2: START (`opCode`=00) issues exactly four micro-steps as {SDA,SCL,sample}: 100, 110, 010, 000. SDA therefore falls while SCL is released, and the sequence ends with both lines low.
- R3: STOP (`opCode`=01) issues exactly four micro-steps: 100, 000, 010, 110. SDA therefore rises while SCL is released, and the sequence ends with both lines released.
- R4: WRITE (`opCode`=10) sends the 8 bits of `txByte` MSB first. Each bit b takes the three steps {b,0,0}, {b,1,0}, {b,0,0}.
- R5: After the data bits, WRITE adds a ninth slot 100, 111, 100, with SDA released and the sample taken in the SCL-high step. The sampled level is returned on `ackStat` (0 = ACK, 1 = NACK).
- R6: READ (`opCode`=11) issues 8 slots of 100, 111, 100. The samples are assembled MSB first into `rxByte`. `rxByte` changes only when a READ completes.
- R7: After the data bits, READ adds a ninth slot {a,0,0}, {a,1,0}, {a,0,0}, where a is the `ackOut` level given with the operation (0 = pull low, ACK; 1 = release, NACK).
- R8: `stepReq` is a one-cycle pulse. The step fields stay unchanged until the driver answers with `stepDone`, and the next request comes only after that answer. A `stepDone` that arrives while no step is outstanding has no effect.
- R9: `opValid` is taken only while `busy` is 0, and `busy` is 1 from the next cycle on. Completion gives a one-cycle `done` with `busy` already 0 and the results already updated. An `opValid` that arrives while `busy` is 1 is ignored.
- R10: Within a byte operation, SDA never changes between two consecutive SCL-high steps, and the sample flag is set only in SCL-high steps. Line levels use 1 = release and 0 = pull low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Start an operation (taken when not busy) |
| opCode | input | 2 | 00 START, 01 STOP, 10 WRITE, 11 READ |
| txByte | input | 8 | Byte to write |
| ackOut | input | 1 | Acknowledge level to send after a read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rxByte | output | 8 | Last byte read |
| ackStat | output | 1 | Acknowledge seen after the last write (0 = ACK) |
| stepReq | output | 1 | One-cycle micro-step request to the line driver |
| stepSda | output | 1 | SDA level for the step (1 = release) |
| stepScl | output | 1 | SCL level for the step (1 = release) |
| stepSample | output | 1 | Sample SDA in this step |
| stepDone | input | 1 | Line driver finished the step |
| sdaIn | input | 1 | Sampled SDA, valid with stepDone |

## Verification
Every byte value goes through both a write and a read. Each is framed by START and STOP, with the driver's answer delay cycling through 0, 1 and 2 cycles. Writing all 256 values with different bit patterns exposes a reversed bit order or a misplaced shift. The read data follows an odd-multiplier permutation, so a sample taken in the wrong step gives the wrong byte. The slave and master acknowledge levels are toggled independently of the data, which separates acknowledge polarity from data bits. A run of requests that arrive while busy, and answers that arrive while idle, must both leave the step stream unchanged.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_STOP  = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } opKind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_ISSUE = 2'b01,
    S_WAIT  = 2'b10
  } seqState_e;

  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobe_t;

  localparam int COND_STEPS = 4;
  localparam int BIT_STEPS  = 3;

endpackage

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic       stepDone,
  input  logic       lastStep,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       stepReq
);

  seqState_e state, stateNext;
  logic doneQ;

  always_comb begin
    strobe.load    = (state == S_IDLE) && opValid;
    strobe.advance = (state == S_WAIT) && stepDone;
  end

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:  if (opValid) stateNext = S_ISSUE;
      S_ISSUE: stateNext = S_WAIT;
      S_WAIT:  if (stepDone) stateNext = lastStep ? S_IDLE : S_ISSUE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= strobe.advance && lastStep;
    end
  end

  assign busy    = (state != S_IDLE);
  assign done    = doneQ;
  assign stepReq = (state == S_ISSUE);

  // R8: a request lasts one cycle only
  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    stepReq |=> !stepReq);

  // R9: completion pulse comes with busy already low, and lasts one cycle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: an accepted operation makes the block busy and issues its first step
  p_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && opValid) |=> (busy && stepReq));

endmodule

// File: rtl/i2c_seq_dp.sv
module i2c_seq_dp
  import i2c_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [1:0]        opCode,
  input  logic [DATA_W-1:0] txByte,
  input  logic              ackOut,
  input  logic              sdaIn,
  output logic              stepSda,
  output logic              stepScl,
  output logic              stepSample,
  output logic              lastStep,
  output logic [DATA_W-1:0] rxByte,
  output logic              ackStat
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [1:0] COND_LAST = 2'(COND_STEPS - 1);
  localparam logic [1:0] BIT_LAST  = 2'(BIT_STEPS - 1);

  logic [1:0]        opReg;
  logic              ackSendQ;
  logic [DATA_W-1:0] shiftQ;
  logic [DATA_W-1:0] rxQ;
  logic              ackQ;
  logic [CNT_W-1:0]  bitCnt;
  logic [1:0]        phase;

  logic isCond, dataSlot, sdaLvl, sclLvl;
  logic [1:0] condLvl;

  // {SDA, SCL} for each step of a bus condition
  function automatic logic [1:0] condLevels(input logic [1:0] op, input logic [1:0] ph);
    logic [1:0] lv;
    if (op == OP_START) begin
      case (ph)
        2'd0:    lv = 2'b10;
        2'd1:    lv = 2'b11;
        2'd2:    lv = 2'b01;
        default: lv = 2'b00;
      endcase
    end else begin
      case (ph)
        2'd0:    lv = 2'b10;
        2'd1:    lv = 2'b00;
        2'd2:    lv = 2'b01;
        default: lv = 2'b11;
      endcase
    end
    return lv;
  endfunction

  always_comb begin
    isCond   = ~opReg[1];
    dataSlot = (bitCnt < LAST_BIT);
    condLvl  = condLevels(opReg, phase);
    sclLvl   = (phase == 2'd1);
    if (opReg == OP_WRITE) sdaLvl = dataSlot ? shiftQ[DATA_W-1] : 1'b1;
    else                   sdaLvl = dataSlot ? 1'b1 : ackSendQ;
    if (isCond) begin
      stepSda    = condLvl[1];
      stepScl    = condLvl[0];
      stepSample = 1'b0;
      lastStep   = (phase == COND_LAST);
    end else begin
      stepSda    = sdaLvl;
      stepScl    = sclLvl;
      stepSample = sclLvl && ((opReg == OP_WRITE) ? !dataSlot : dataSlot);
      lastStep   = (phase == BIT_LAST) && (bitCnt == LAST_BIT);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg    <= OP_STOP;
      ackSendQ <= 1'b1;
      shiftQ   <= '0;
      rxQ      <= '0;
      ackQ     <= 1'b1;
      bitCnt   <= '0;
      phase    <= COND_LAST;
    end else if (strobe.load) begin
      opReg    <= opCode;
      ackSendQ <= ackOut;
      shiftQ   <= txByte;
      bitCnt   <= '0;
      phase    <= '0;
    end else if (strobe.advance) begin
      if (isCond) begin
        phase <= phase + 2'd1;
      end else begin
        if (stepSample) begin
          if (dataSlot) shiftQ <= {shiftQ[DATA_W-2:0], sdaIn};
          else          ackQ   <= sdaIn;
        end
        if (phase == BIT_LAST) begin
          phase  <= '0;
          bitCnt <= bitCnt + CNT_W'(1);
          if (opReg == OP_WRITE && dataSlot) shiftQ <= {shiftQ[DATA_W-2:0], 1'b1};
        end else begin
          phase <= phase + 2'd1;
        end
        if (lastStep && opReg == OP_READ) rxQ <= shiftQ;
      end
    end
  end

  assign rxByte  = rxQ;
  assign ackStat = ackQ;

  // R8: step fields hold while no step is loaded or completed
  p_hold_fields_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.advance) |=> $stable({stepSda, stepScl, stepSample, lastStep}));

  // R10: sampling only while SCL is released
  p_sample_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    stepSample |-> stepScl);

  // R5 and R6: results move only when a step completes
  p_results_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable({rxByte, ackStat}));

  // R4: the bit counter never passes the acknowledge slot
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    !isCond |-> (bitCnt <= LAST_BIT + CNT_W'(1)));

endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
  import i2c_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opCode,
  input  logic [DATA_W-1:0] txByte,
  input  logic              ackOut,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxByte,
  output logic              ackStat,
  output logic              stepReq,
  output logic              stepSda,
  output logic              stepScl,
  output logic              stepSample,
  input  logic              stepDone,
  input  logic              sdaIn
);

  seqStrobe_t strobe;
  logic lastStep;

  i2c_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .stepDone (stepDone),
    .lastStep (lastStep),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .stepReq  (stepReq)
  );

  i2c_seq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opCode     (opCode),
    .txByte     (txByte),
    .ackOut     (ackOut),
    .sdaIn      (sdaIn),
    .stepSda    (stepSda),
    .stepScl    (stepScl),
    .stepSample (stepSample),
    .lastStep   (lastStep),
    .rxByte     (rxByte),
    .ackStat    (ackStat)
  );

endmodule

// File: tb/sim_i2c_byte_seq.sv
module sim_i2c_byte_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [1:0] opCode = 2'b00;
  logic [7:0] txByte = 8'h00;
  logic ackOut = 1'b0;
  logic busy, done, ackStat, stepReq, stepSda, stepScl, stepSample;
  logic [7:0] rxByte;
  logic stepDone = 1'b0;
  logic sdaIn = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [2:0] logArr [0:63];
  int logCnt = 0;
  logic [2:0] expArr [0:63];
  int expCnt = 0;
  logic [8:0] respVec = '1;
  int respIdx = 0;
  int latency = 0;

  always #2 clk = ~clk;

  i2c_byte_seq u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .txByte(txByte),
    .ackOut(ackOut), .busy(busy), .done(done), .rxByte(rxByte), .ackStat(ackStat),
    .stepReq(stepReq), .stepSda(stepSda), .stepScl(stepScl), .stepSample(stepSample),
    .stepDone(stepDone), .sdaIn(sdaIn)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // line driver model: logs each step, holds it, then answers
  initial begin
    forever begin
      @(negedge clk);
      while (stepReq) begin
        logic [2:0] cur;
        cur = {stepSda, stepScl, stepSample};
        if (logCnt < 64) logArr[logCnt] = cur;
        logCnt++;
        for (int k = 0; k <= latency; k++) begin
          @(negedge clk);
          chk(!stepReq && ({stepSda, stepScl, stepSample} == cur), "R8",
              "step held until answered", int'({stepReq, stepSda, stepScl, stepSample}), int'({1'b0, cur}));
        end
        if (cur[0]) begin
          sdaIn = respVec[8 - respIdx];
          respIdx++;
        end
        stepDone = 1'b1;
        @(negedge clk);
        stepDone = 1'b0;
      end
    end
  end

  task automatic pushExp(input logic [2:0] e);
    if (expCnt < 64) expArr[expCnt] = e;
    expCnt++;
  endtask

  task automatic buildCond(input bit isStart);
    expCnt = 0;
    if (isStart) begin
      pushExp(3'b100); pushExp(3'b110); pushExp(3'b010); pushExp(3'b000);
    end else begin
      pushExp(3'b100); pushExp(3'b000); pushExp(3'b010); pushExp(3'b110);
    end
  endtask

  task automatic buildWrite(input logic [7:0] v);
    expCnt = 0;
    for (int i = 0; i < 8; i++) begin
      pushExp({v[7-i], 2'b00}); pushExp({v[7-i], 2'b10}); pushExp({v[7-i], 2'b00});
    end
    pushExp(3'b100); pushExp(3'b111); pushExp(3'b100);
  endtask

  task automatic buildRead(input logic a);
    expCnt = 0;
    for (int i = 0; i < 8; i++) begin
      pushExp(3'b100); pushExp(3'b111); pushExp(3'b100);
    end
    pushExp({a, 2'b00}); pushExp({a, 2'b10}); pushExp({a, 2'b00});
  endtask

  task automatic checkSeq(input string req);
    int firstBad;
    firstBad = -1;
    chk(logCnt == expCnt, req, "step count", logCnt, expCnt);
    for (int i = 0; i < expCnt && i < logCnt && i < 64; i++)
      if (firstBad < 0 && logArr[i] !== expArr[i]) firstBad = i;
    if (firstBad >= 0)
      chk(1'b0, req, $sformatf("step %0d pattern", firstBad), int'(logArr[firstBad]), int'(expArr[firstBad]));
    else
      chk(1'b1, req, "step pattern", 0, 0);
  endtask

  // R10: in byte operations SDA holds across consecutive SCL-high steps; sample only with SCL high
  task automatic checkLineRule();
    bit ok;
    ok = 1'b1;
    for (int i = 0; i < logCnt && i < 64; i++) begin
      if (logArr[i][0] && !logArr[i][1]) ok = 1'b0;
      if (i > 0 && logArr[i-1][1] && logArr[i][1] && (logArr[i-1][2] != logArr[i][2])) ok = 1'b0;
    end
    chk(ok, "R10", "SDA stable while SCL high", int'(ok), 1);
  endtask

  task automatic runOp(input logic [1:0] op, input logic [7:0] tx, input logic ackO,
                       input logic [8:0] resp, input int lat, input bit meddle);
    int cyc;
    latency = lat; respVec = resp; respIdx = 0; logCnt = 0;
    @(negedge clk);
    opValid = 1'b1; opCode = op; txByte = tx; ackOut = ackO;
    @(negedge clk);
    opValid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    if (meddle) begin
      opValid = 1'b1; opCode = 2'b01; txByte = ~tx; ackOut = ~ackO;
      repeat (10) @(negedge clk);
      opValid = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R9", "done reached", int'(done), 1);
    chk(busy == 1'b0, "R9", "busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done lasts one cycle", int'(done), 0);
  endtask

  initial begin
    logic [7:0] rd, prevRd;
    logic ackExp, ackO;
    prevRd = 8'h00;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy at reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done at reset", int'(done), 0);
    chk(stepReq == 1'b0, "R1", "stepReq at reset", int'(stepReq), 0);
    chk(rxByte == 8'h00, "R1", "rxByte at reset", int'(rxByte), 0);
    chk(ackStat == 1'b1, "R1", "ackStat at reset", int'(ackStat), 1);
    rstN = 1'b1;
    @(negedge clk);

    // R8: an answer with no outstanding step changes nothing
    stepDone = 1'b1;
    repeat (3) @(negedge clk);
    stepDone = 1'b0;
    chk(done == 1'b0 && busy == 1'b0 && stepReq == 1'b0, "R8", "stray stepDone ignored",
        int'({done, busy, stepReq}), 0);

    for (int v = 0; v < 256; v++) begin
      rd = 8'((v * 37 + 11) & 255);
      ackExp = logic'(v & 1) ^ logic'((v >> 5) & 1);
      ackO = logic'((v >> 2) & 1);

      buildCond(1'b1);
      runOp(2'b00, 8'h00, 1'b0, 9'h1FF, v % 3, 1'b0);
      checkSeq("R2");

      buildWrite(8'(v));
      runOp(2'b10, 8'(v), 1'b0, {ackExp, 8'hFF}, (v + 1) % 3, (v % 64) == 13);
      checkSeq("R4");
      checkLineRule();
      chk(ackStat == ackExp, "R5", "write acknowledge", int'(ackStat), int'(ackExp));
      chk(rxByte == prevRd, "R6", "rxByte held across write", int'(rxByte), int'(prevRd));

      buildRead(ackO);
      runOp(2'b11, 8'(~v), ackO, {rd, 1'b1}, (v + 2) % 3, (v % 64) == 40);
      checkSeq("R6");
      checkLineRule();
      chk(rxByte == rd, "R6", "read byte", int'(rxByte), int'(rd));
      chk(logArr[25] == {ackO, 2'b10}, "R7", "ninth slot acknowledge level",
          int'(logArr[25]), int'({ackO, 2'b10}));
      prevRd = rd;

      buildCond(1'b0);
      runOp(2'b01, 8'h00, 1'b0, 9'h1FF, v % 2, 1'b0);
      checkSeq("R3");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 190000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule